// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Commit

This block turns one of several reference clock-enable streams into a slower enable pulse train on the same clock. The chosen source first passes through an integer pre-divider and then a fractional divider. The fractional divider keeps a phase accumulator, so the output pulses have the correct average rate even when the divisor is not a whole number. Both divisor fields store the divisor less one. In the fractional field the three low bits sit to the right of the binary point, and the implied one is added only to the integer part above them.

Software sets up a new source select, pre-divider or divider in staged fields, and these values have no effect until a trigger is written. The pre-trigger commits the source select and the pre-divider together. The main trigger commits the fractional divider. A trigger reads 1 from the write until the change is done. The change is applied at the end of the output period that is running, and the trigger clears on the next cycle. A gate input freezes the block. While the gate is off, trigger writes are discarded.

Top module: `fracClkDiv`

## Requirements
- R1: With the divider field F = 8*(k-1) and no fraction bits, an output pulse is issued exactly every k selected-source ticks after the pre-divider. After reset F is 0, the pre-divider field is 0 and the select is 0, so with a source that ticks every cycle outEn pulses every cycle.
- R2: When the low 3 bits of F are nonzero, the divisor is (F[7:3]+1) + F[2:0]/8. Over a long window the output pulse count equals the input tick count divided by that divisor, within one pulse.
- R3: The 4-bit pre-divider field P passes one selected-source tick in every P+1 on to the fractional divider.
- R4: The 2-bit select value s makes refEn[s] the source stream.
- R5: A change to a staged field with no trigger write leaves the output rate unchanged.
- R6: A trigger status reads 1 from the cycle after its write strobe until the commit completes. It returns to 0 exactly one cycle after the output pulse at which the new values were loaded.
- R7: A commit waits for the current output period to finish, so the interval that contains the trigger write keeps the old divisor. Every later interval uses the new one.
- R8: The pre-trigger loads only the select and the pre-divider. The main trigger loads only the fractional divider.
- R9: A trigger write while gateEn is 0 is discarded. Its status stays 0, and the committed rate is unchanged once the gate returns.
- R10: While gateEn is 0, outEn stays 0 and no divider state advances.
- R11: During and right after reset, both trigger statuses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 4 | Reference clock-enable streams, one per source |
| gateEn | input | 1 | Clock gate. When 0, the block is frozen and ignores triggers |
| selStage | input | 2 | Staged source select |
| preDivStage | input | 4 | Staged pre-divider, divisor minus one |
| divStage | input | 8 | Staged fractional divider, divisor minus one, 3 fraction bits |
| preTrigWr | input | 1 | Strobe that requests a commit of the select and the pre-divider |
| trigWr | input | 1 | Strobe that requests a commit of the fractional divider |
| outEn | output | 1 | Divided clock-enable pulse |
| preTrigBusy | output | 1 | Pre-trigger status, 1 while its commit is pending |
| trigBusy | output | 1 | Main trigger status, 1 while its commit is pending |

## Verification
The properties assume that reset is asserted at the start, and that the gate and trigger strobes are synchronous single-cycle-safe levels. They also assume that a pending commit can only end at an output pulse, which requires the selected source to keep ticking while the gate is on. The stimulus keeps one reference stream running every cycle and holds each staged field steady from the trigger write until its status clears. It changes the gate only while no commit is pending.

// File: rtl/fracClkDivPkg.sv
package fracClkDivPkg;

  typedef struct packed {
    logic loadPre;
    logic loadDiv;
  } commitStrobe_t;

  typedef enum logic [1:0] {
    TRIG_IDLE = 2'd0,
    TRIG_WAIT = 2'd1,
    TRIG_DONE = 2'd2
  } trigState_t;

endpackage

// File: rtl/fracDivCtrl.sv
module fracDivCtrl
  import fracClkDivPkg::*;
#(
  parameter int TRIG_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gateEn,
  input  logic [TRIG_N-1:0] trigReq,
  input  logic              periodEnd,
  output logic [TRIG_N-1:0] busy,
  output commitStrobe_t     strobe
);

  logic [TRIG_N-1:0] loadNow;

  for (genvar g = 0; g < TRIG_N; g++) begin : gTrig
    trigState_t state;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state <= TRIG_IDLE;
      end else begin
        case (state)
          TRIG_IDLE: if (trigReq[g] && gateEn) state <= TRIG_WAIT;
          TRIG_WAIT: if (periodEnd) state <= TRIG_DONE;
          TRIG_DONE: state <= TRIG_IDLE;
          default:   state <= TRIG_IDLE;
        endcase
      end
    end

    assign loadNow[g] = (state == TRIG_WAIT) && periodEnd;
    assign busy[g]    = (state != TRIG_IDLE);
  end

  // index 0 is the pre-trigger, index 1 the main trigger
  assign strobe.loadPre = loadNow[0];
  assign strobe.loadDiv = loadNow[1];

endmodule

// File: rtl/fracDivPath.sv
module fracDivPath
  import fracClkDivPkg::*;
#(
  parameter int SRC_N  = 4,
  parameter int PRE_W  = 4,
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 3,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateEn,
  input  logic [SRC_N-1:0] refEn,
  input  logic [SEL_W-1:0] selStage,
  input  logic [PRE_W-1:0] preDivStage,
  input  logic [DIV_W-1:0] divStage,
  input  commitStrobe_t    strobe,
  output logic             periodEnd,
  output logic             outEn
);

  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [SEL_W-1:0] selCur;
  logic [PRE_W-1:0] preDivCur;
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCur;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] scaledDiv;
  logic             srcTick;
  logic             preWrap;
  logic             preTick;
  logic             hit;

  assign srcTick   = gateEn && refEn[selCur];
  assign preWrap   = (preCnt == preDivCur);
  assign preTick   = srcTick && preWrap;
  // scaled divisor: the implied one lands just above the fraction bits
  assign scaledDiv = ACC_W'(divCur) + UNIT;
  assign accNext   = acc + UNIT;
  assign hit       = preTick && (accNext >= scaledDiv);
  assign periodEnd = hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selCur    <= '0;
      preDivCur <= '0;
      preCnt    <= '0;
    end else begin
      if (srcTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (strobe.loadPre) begin
        selCur    <= selStage;
        preDivCur <= preDivStage;
        preCnt    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCur <= '0;
      acc    <= '0;
      outEn  <= 1'b0;
    end else begin
      outEn <= hit;
      if (preTick) acc <= hit ? accNext - scaledDiv : accNext;
      if (strobe.loadDiv) begin
        divCur <= divStage;
        acc    <= '0;
      end
    end
  end

endmodule

// File: rtl/fracClkDiv.sv
module fracClkDiv
  import fracClkDivPkg::*;
#(
  parameter int SRC_N  = 4,
  parameter int PRE_W  = 4,
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 3,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] refEn,
  input  logic             gateEn,
  input  logic [SEL_W-1:0] selStage,
  input  logic [PRE_W-1:0] preDivStage,
  input  logic [DIV_W-1:0] divStage,
  input  logic             preTrigWr,
  input  logic             trigWr,
  output logic             outEn,
  output logic             preTrigBusy,
  output logic             trigBusy
);

  commitStrobe_t strobe;
  logic          periodEnd;
  logic [1:0]    busy;

  fracDivCtrl #(.TRIG_N(2)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gateEn   (gateEn),
    .trigReq  ({trigWr, preTrigWr}),
    .periodEnd(periodEnd),
    .busy     (busy),
    .strobe   (strobe)
  );

  fracDivPath #(
    .SRC_N (SRC_N),
    .PRE_W (PRE_W),
    .DIV_W (DIV_W),
    .FRAC_W(FRAC_W)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .gateEn     (gateEn),
    .refEn      (refEn),
    .selStage   (selStage),
    .preDivStage(preDivStage),
    .divStage   (divStage),
    .strobe     (strobe),
    .periodEnd  (periodEnd),
    .outEn      (outEn)
  );

  assign preTrigBusy = busy[0];
  assign trigBusy    = busy[1];

endmodule

// File: rtl/fracClkDivChk.sv
module fracClkDivChk (
  input logic clk,
  input logic rstN,
  input logic gateEn,
  input logic preBusy,
  input logic mainBusy,
  input logic outEn
);

  assert_gated_write_pre_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEn && !preBusy) |=> !preBusy);

  assert_gated_write_main_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!gateEn && !mainBusy) |=> !mainBusy);

  assert_rise_needs_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainBusy) |-> $past(gateEn));

  assert_no_pulse_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> $past(gateEn));

  assert_busy_min_span_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainBusy) |-> $past(mainBusy, 2));

  assert_clear_after_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainBusy) |-> $past(outEn));

  assert_pre_clear_after_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(preBusy) |-> $past(outEn));

endmodule

bind fracClkDiv fracClkDivChk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .gateEn  (gateEn),
  .preBusy (preTrigBusy),
  .mainBusy(trigBusy),
  .outEn   (outEn)
);

// File: tb/test_fracClkDiv.sv
`timescale 1ns/1ps
module test_fracClkDiv;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] refEn = 4'b0001;
  logic       gateEn = 1'b1;
  logic [1:0] selStage = '0;
  logic [3:0] preDivStage = '0;
  logic [7:0] divStage = '0;
  logic       preTrigWr = 1'b0;
  logic       trigWr = 1'b0;
  logic       outEn;
  logic       preTrigBusy;
  logic       trigBusy;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  fracClkDiv i_fracClkDiv (
    .clk(clk), .rstN(rstN), .refEn(refEn), .gateEn(gateEn),
    .selStage(selStage), .preDivStage(preDivStage), .divStage(divStage),
    .preTrigWr(preTrigWr), .trigWr(trigWr), .outEn(outEn),
    .preTrigBusy(preTrigBusy), .trigBusy(trigBusy)
  );

  always #2 clk = ~clk;

  // reference streams: 0 every cycle, 1 every 2nd, 2 every 3rd, 3 never
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 6;
      refEn = {1'b0, (ph % 3) == 0, (ph % 2) == 0, 1'b1};
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog: actual %0d cycles, expected below 100000", cycles);
        finishRun();
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPulse();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!outEn && n < 2000);
  endtask

  task automatic interval(output int n);
    waitPulse();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!outEn && n < 2000);
  endtask

  task automatic countPulses(input int window, output int c);
    c = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (outEn) c++;
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    while ((preTrigBusy || trigBusy) && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic commit(input bit doPre, input bit doMain);
    @(negedge clk);
    preTrigWr = doPre;
    trigWr    = doMain;
    @(negedge clk);
    preTrigWr = 1'b0;
    trigWr    = 1'b0;
    waitIdle();
  endtask

  task automatic testReset();
    int n;
    check(!preTrigBusy && !trigBusy, "R11 busy after reset", {preTrigBusy, trigBusy}, 0);
    interval(n);
    check(n == 1, "R1 default divide by one", n, 1);
  endtask

  task automatic testIntegerAndScope();
    int n;
    selStage = 2'd2; preDivStage = 4'd3; divStage = 8'd24;
    commit(1'b0, 1'b1);
    interval(n);
    check(n == 4, "R1 R8 divide by 4, select and pre untouched", n, 4);
  endtask

  task automatic testStagedNoEffect();
    int n;
    divStage = 8'd0;
    repeat (50) @(negedge clk);
    interval(n);
    check(n == 4, "R5 staged divider without trigger", n, 4);
  endtask

  task automatic testFraction();
    int c;
    divStage = 8'd4;
    commit(1'b0, 1'b1);
    countPulses(120, c);
    check(c >= 79 && c <= 81, "R2 divide by 1.5", c, 80);
    divStage = 8'd12;
    commit(1'b0, 1'b1);
    countPulses(120, c);
    check(c >= 47 && c <= 49, "R2 divide by 2.5", c, 48);
  endtask

  task automatic testPreDiv();
    int n;
    int c;
    divStage = 8'd0;
    commit(1'b0, 1'b1);
    selStage = 2'd0; preDivStage = 4'd2;
    commit(1'b1, 1'b0);
    interval(n);
    check(n == 3, "R3 pre-divide by 3", n, 3);
    preDivStage = 4'd1; divStage = 8'd4;
    commit(1'b1, 1'b1);
    countPulses(120, c);
    check(c >= 39 && c <= 41, "R3 R2 pre 2 times 1.5", c, 40);
  endtask

  task automatic testSelect();
    int n;
    divStage = 8'd0;
    commit(1'b0, 1'b1);
    selStage = 2'd2; preDivStage = 4'd0;
    commit(1'b1, 1'b0);
    interval(n);
    check(n == 3, "R4 select source 2", n, 3);
    selStage = 2'd1;
    commit(1'b1, 1'b0);
    interval(n);
    check(n == 2, "R4 select source 1", n, 2);
  endtask

  task automatic testCommitTiming();
    int n;
    selStage = 2'd0;
    commit(1'b1, 1'b0);
    divStage = 8'd56;
    commit(1'b0, 1'b1);
    waitPulse();
    divStage = 8'd8;
    trigWr = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      trigWr = 1'b0;
      n++;
      if (n == 1) check(trigBusy, "R6 busy after write", trigBusy, 1);
    end while (!outEn && n < 2000);
    check(n == 8, "R7 old period completes", n, 8);
    check(trigBusy, "R6 busy at commit pulse", trigBusy, 1);
    @(negedge clk);
    check(!trigBusy, "R6 clear one cycle after commit", trigBusy, 0);
    interval(n);
    check(n == 2, "R7 new divisor after commit", n, 2);
  endtask

  task automatic testGate();
    int n;
    int c;
    bit sawBusy = 1'b0;
    @(negedge clk);
    gateEn = 1'b0;
    divStage = 8'd0; preDivStage = 4'd5;
    trigWr = 1'b1; preTrigWr = 1'b1;
    @(negedge clk);
    trigWr = 1'b0; preTrigWr = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (trigBusy || preTrigBusy) sawBusy = 1'b1;
      if (outEn) c++;
    end
    check(!sawBusy, "R9 gated trigger ignored", sawBusy, 0);
    countPulses(40, c);
    check(c == 0, "R10 no pulses while gated", c, 0);
    gateEn = 1'b1;
    interval(n);
    check(n == 2, "R9 R10 rate kept after gate", n, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIntegerAndScope();
    testStagedNoEffect();
    testFraction();
    testPreDiv();
    testSelect();
    testCommitTiming();
    testGate();
    finishRun();
  end

endmodule